// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block keeps a 32-bit cycle counter that advances once per clock while the timer is active, and a 32-bit compare value set by software. When the counter reaches the compare value, a latched interrupt line rises. The line stays high until software writes the compare register. The usual way to use it is to leave the counter free-running and, in each interrupt handler, write compare to a later value. This re-arms the timer and clears the interrupt in a single access.

Counting is gated. A stop bit in the configuration word holds the counter. A power-mode input lets the counter run in light sleep and halts it in deep power-down. An optional auto-clear mode sends the counter back to zero on a match, so a fixed compare value gives a periodic tick. Software must leave at least one idle cycle between two writes to the counter. If a counter write is strobed in the cycle right after another counter write, the block drops the second write, and software must treat the resulting value as undefined.

Top module: `cmp_tick_timer`

## Requirements
- R1: A write strobe with `reg_sel`=0 loads the counter, and with `reg_sel`=1 loads the compare register. The new value is visible on `rd_data` one cycle later. `rd_sel`=0 reads the counter and `rd_sel`=1 reads compare, combinationally.
- R2: After reset the counter reads 0, compare reads 0xFFFFFFFF, and `irq` is low.
- R3: While the timer is active, the counter rises by exactly one per clock. It wraps from 0xFFFFFFFF to 0 and keeps counting.
- R4: While `cfg_bits[3]` is 1, the counter holds its value. Clearing that bit resumes counting. All other `cfg_bits` have no effect.
- R5: With `pwr_mode` 2'b00 (active) or 2'b01 (light sleep), the counter runs. With 2'b10 (deep power-down) or 2'b11 (reserved), it holds.
- R6: `irq` rises in the cycle after the one in which the counter equals compare.
- R7: Once high, `irq` stays high until a compare write. It is low in the cycle after that write, whatever value was written.
- R8: With `auto_clear`=1 and the timer active, a match makes the counter read 0 in the next cycle and 1 in the cycle after.
- R9: A register write takes priority over increment and auto-clear in the same cycle, so the counter reads exactly the written value.
- R10: Writing the counter with the value already held in compare makes `irq` rise two cycles after the write strobe, whether or not the timer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; one tick per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 counter, 1 compare |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 counter, 1 compare |
| rd_data | output | 32 | Selected register value |
| cfg_bits | input | 8 | Configuration word; bit 3 stops the counter |
| pwr_mode | input | 2 | 00 active, 01 light sleep, 10 deep power-down, 11 reserved |
| auto_clear | input | 1 | 1: a match returns the counter to zero |
| irq | output | 1 | Latched terminal-count interrupt |

## Verification
A match is the hard condition to reach from the ports. With random 32-bit values, the counter and compare almost never meet. It is harder still to hit a match at the same moment as a stop, a sleep-mode change, auto-clear, or a compare write. To get there, the random phase writes compare to the bench model's current count plus a small offset, and sometimes writes the counter to a value just below compare. Meanwhile it flips the stop bit, the power mode and auto-clear every few cycles. Directed sequences cover the wrap at 0xFFFFFFFF, the match that comes straight after a counter write, and the interrupt being held until compare is rewritten.

// File: rtl/tmr_pkg.sv
// Shared definitions for the count/compare timer.
// Assumes: single clock domain, 1-bit register select.
package tmr_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'b00,
        PWR_SLEEP  = 2'b01,
        PWR_DEEP   = 2'b10,
        PWR_RSVD   = 2'b11
    } pwr_mode_e;

    localparam logic SEL_COUNT = 1'b0;
    localparam logic SEL_CMP   = 1'b1;

endpackage

// File: rtl/tmr_run_gate.sv
// Run qualifier: decides whether the counter may advance this cycle.
// Assumes: the stop bit is level-sensitive; bit 1 of the power mode marks
// deep power-down (or the reserved code), bit 0 (light sleep) keeps counting.
module tmr_run_gate #(
    parameter int CFG_W    = 8,
    parameter int STOP_BIT = 3
) (
    input  logic [CFG_W-1:0] cfg_bits,
    input  logic [1:0]       pwr_mode,
    output logic             run
);
    import tmr_pkg::*;

    pwr_mode_e mode;
    logic      pwr_halt;

    // Decode the power mode into a halt request.
    always_comb begin
        mode = pwr_mode_e'(pwr_mode);
        unique case (mode)
            PWR_ACTIVE, PWR_SLEEP: pwr_halt = 1'b0;
            PWR_DEEP, PWR_RSVD:    pwr_halt = 1'b1;
            default:               pwr_halt = 1'b1;
        endcase
    end

    // Combine stop bit and power halt into the run enable.
    always_comb begin
        run = !cfg_bits[STOP_BIT] && !pwr_halt;
    end

endmodule

// File: rtl/tmr_count_reg.sv
// Cycle counter register: write > match clear > increment > hold.
// Assumes: a write strobed in the cycle right after another write is dropped
// (software must space writes); the counter wraps modulo 2**W.
module tmr_count_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr_req,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_q;
    logic         wr_last_q;
    logic         wr_take;

    // Accept a write only if the previous cycle carried none.
    always_comb begin
        wr_take = wr_en && !wr_last_q;
    end

    // Counter state update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            wr_last_q <= 1'b0;
        end else begin
            wr_last_q <= wr_en;
            if (wr_take) begin
                count_q <= wr_data;
            end else if (run && clr_req) begin
                count_q <= '0;
            end else if (run) begin
                count_q <= count_q + ONE;
            end
        end
    end

    assign count = count_q;

    AST_CNT_RST: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_en && !clr_req) |=> (count_q == $past(count_q) + ONE)); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(count_q)); // R4

    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_last_q) |=> (count_q == $past(wr_data))); // R9

endmodule

// File: rtl/tmr_match_irq.sv
// Compare register, equality detect and latched terminal-count interrupt.
// Assumes: equality is sampled every cycle regardless of run state; a
// compare write clears the latch and outranks a match in the same cycle.
module tmr_match_irq #(
    parameter int           W       = 32,
    parameter logic [W-1:0] CMP_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic [W-1:0] count,
    output logic [W-1:0] cmp_val,
    output logic         eq,
    output logic         irq
);
    logic [W-1:0] cmp_q;
    logic         irq_q;

    // Equality between running count and compare value.
    always_comb begin
        eq = (count == cmp_q);
    end

    // Compare register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= CMP_RST;
        end else if (cmp_wr) begin
            cmp_q <= cmp_wdata;
        end
    end

    // Interrupt latch: set by match, cleared only by compare write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (cmp_wr) begin
            irq_q <= 1'b0;
        end else if (eq) begin
            irq_q <= 1'b1;
        end
    end

    assign cmp_val = cmp_q;
    assign irq     = irq_q;

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (count == cmp_q && !cmp_wr) |=> irq_q); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !cmp_wr) |=> irq_q); // R7

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> (!irq_q && cmp_q == $past(cmp_wdata))); // R7

endmodule

// File: rtl/cmp_tick_timer.sv
// Count/compare interval timer top: a free-running counter, a compare
// register and a latched match interrupt behind a one-port register access.
// Assumes: one register written per cycle; reads are combinational.
module cmp_tick_timer #(
    parameter int W        = 32,
    parameter int CFG_W    = 8,
    parameter int STOP_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [W-1:0]     reg_wdata,
    input  logic             rd_sel,
    output logic [W-1:0]     rd_data,
    input  logic [CFG_W-1:0] cfg_bits,
    input  logic [1:0]       pwr_mode,
    input  logic             auto_clear,
    output logic             irq
);
    import tmr_pkg::*;

    logic         run;
    logic         eq;
    logic         clr_req;
    logic         wr_cnt;
    logic         wr_cmp;
    logic [W-1:0] count;
    logic [W-1:0] cmp_val;

    // Split the write strobe by target register.
    always_comb begin
        wr_cnt = reg_wr && (reg_sel == SEL_COUNT);
        wr_cmp = reg_wr && (reg_sel == SEL_CMP);
    end

    // Auto-clear request when the mode is on and a match is present.
    always_comb begin
        clr_req = auto_clear && eq;
    end

    // Read-back multiplexer.
    always_comb begin
        rd_data = (rd_sel == SEL_CMP) ? cmp_val : count;
    end

    tmr_run_gate #(.CFG_W(CFG_W), .STOP_BIT(STOP_BIT)) u_gate (
        .cfg_bits (cfg_bits),
        .pwr_mode (pwr_mode),
        .run      (run)
    );

    tmr_count_reg #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clr_req (clr_req),
        .wr_en   (wr_cnt),
        .wr_data (reg_wdata),
        .count   (count)
    );

    tmr_match_irq #(.W(W), .CMP_RST('1)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_wr    (wr_cmp),
        .cmp_wdata (reg_wdata),
        .count     (count),
        .cmp_val   (cmp_val),
        .eq        (eq),
        .irq       (irq)
    );

    AST_AUTO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clear && run && count == cmp_val && !reg_wr) |=> (count == '0)); // R8

    AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode[1] && !reg_wr) |=> $stable(count)); // R5

endmodule

// File: tb/sim_cmp_tick_timer.sv
module sim_cmp_tick_timer;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  cfg_bits = '0;
    logic [1:0]  pwr_mode = 2'b00;
    logic        auto_clear = 1'b0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [31:0] m_cnt, m_cmp;
    logic        m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .cfg_bits(cfg_bits), .pwr_mode(pwr_mode), .auto_clear(auto_clear),
        .irq(irq)
    );

    always @(posedge clk) cycles <= cycles + 1;

    function automatic logic runs(logic [7:0] cfg, logic [1:0] pm);
        return !cfg[3] && !pm[1];
    endfunction

    function automatic logic [31:0] next_cnt(logic [31:0] c, logic [31:0] k,
            logic wr, logic sel, logic [31:0] wd, logic run, logic ac);
        if (wr && !sel) return wd;
        if (run && ac && c == k) return 32'h0;
        if (run) return c + 32'd1;
        return c;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic observe(string tag);
        rd_sel = 1'b0; #1;
        check(tag, "count", rd_data, m_cnt);
        rd_sel = 1'b1; #1;
        check(tag, "compare", rd_data, m_cmp);
        check(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
    endtask

    // One clock: model advances from the inputs set in the low phase.
    task automatic step(string tag);
        logic        eqv, rn;
        logic [31:0] nc;
        @(posedge clk);
        eqv = (m_cnt == m_cmp);
        rn  = runs(cfg_bits, pwr_mode);
        nc  = next_cnt(m_cnt, m_cmp, reg_wr, reg_sel, reg_wdata, rn, auto_clear);
        m_irq = (reg_wr && reg_sel) ? 1'b0 : (m_irq | eqv);
        if (reg_wr && reg_sel) m_cmp = reg_wdata;
        m_cnt = nc;
        @(negedge clk);
        reg_wr = 1'b0;
        observe(tag);
    endtask

    task automatic wr_reg(logic sel, logic [31:0] d, string tag);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic prev_cw;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 32'h0; m_cmp = 32'hFFFF_FFFF; m_irq = 1'b0;
        observe("R2");

        idle(5, "R3");
        wr_reg(1'b1, 32'h0000_0100, "R1");
        wr_reg(1'b0, 32'h0000_0050, "R1");
        idle(1, "R1");
        wr_reg(1'b0, 32'h0000_0060, "R9");
        idle(3, "R3");

        // wrap
        wr_reg(1'b0, 32'hFFFF_FFFE, "R3");
        idle(4, "R3");

        // stop bit and other config bits
        cfg_bits = 8'h08; idle(5, "R4");
        cfg_bits = 8'hF7; idle(5, "R4");
        cfg_bits = 8'h00;

        // power modes
        pwr_mode = 2'b01; idle(4, "R5");
        pwr_mode = 2'b10; idle(4, "R5");
        pwr_mode = 2'b11; idle(3, "R5");
        pwr_mode = 2'b00;

        // match, sticky interrupt, clear by compare write
        wr_reg(1'b0, 32'h0000_00FD, "R6");
        idle(6, "R6");
        idle(8, "R7");
        wr_reg(1'b1, 32'h0000_5000, "R7");
        idle(2, "R7");

        // count written equal to compare while stopped
        cfg_bits = 8'h08;
        wr_reg(1'b0, 32'h0000_5000, "R10");
        idle(3, "R10");
        cfg_bits = 8'h00;
        wr_reg(1'b1, 32'h0000_0040, "R7");

        // auto-clear periodic tick
        auto_clear = 1'b1;
        wr_reg(1'b0, 32'h0000_003C, "R8");
        idle(14, "R8");
        wr_reg(1'b1, 32'h0000_0005, "R8");
        idle(10, "R8");
        auto_clear = 1'b0;

        // constrained random phase
        prev_cw = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if (i % 16 == 0) begin
                cfg_bits   = 8'($urandom) & 8'hF7;
                if ($urandom_range(0, 7) == 0) cfg_bits[3] = 1'b1;
                pwr_mode   = 2'($urandom);
                auto_clear = ($urandom_range(0, 3) == 0);
            end
            if (!prev_cw && $urandom_range(0, 9) == 0) begin
                reg_wr = 1'b1; reg_sel = 1'b0;
                reg_wdata = ($urandom_range(0, 1) == 0) ? 32'($urandom)
                          : m_cmp - 32'($urandom_range(0, 6));
                prev_cw = 1'b1;
            end else if ($urandom_range(0, 9) == 0) begin
                reg_wr = 1'b1; reg_sel = 1'b1;
                reg_wdata = m_cnt + 32'($urandom_range(0, 8));
                prev_cw = 1'b0;
            end else begin
                prev_cw = 1'b0;
            end
            step("R1 R3 R6");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule